// File: doc/BRIEF.md
# Pixel Clock Enable Divider

This block derives a pixel-rate enable strobe from a fast master clock for an on-screen display pipeline. It never gates or switches the clock. Instead it raises a one-cycle enable that downstream registers qualify their updates with. A 3-bit ratio code picks the rate: quarter, third or half of the master rate, a two-thirds fractional rate, or full rate. A 2-bit oscillator-source code is used only to reject full rate when the fast oscillator is the master.

Ratio changes are applied only at the end of the current enable period, so the strobe never produces a truncated or stretched period. Reserved codes, and the full-rate code when the oscillator source is 00, fall back to quarter rate and raise a configuration-error flag.

Top module: `pixclk_div`

## Requirements
- R1: With ratio code 000 active, `pix_en` is high for one cycle in every 4 master cycles, on the last cycle of each 4-cycle period.
- R2: With ratio code 001 active, `pix_en` is high for one cycle in every 3 master cycles, on the last cycle of each period.
- R3: With ratio code 010 active, `pix_en` is high on every second master cycle, on the last cycle of each 2-cycle period.
- R4: With ratio code 011 active, `pix_en` follows a 3-cycle pattern of high, high, low, starting at the first cycle of the period.
- R5: With ratio code 100 and an oscillator-source code other than 00, `pix_en` is high on every master cycle.
- R6: Ratio code 100 with oscillator-source code 00 is prohibited: the block runs at quarter rate (as R1) and `cfg_err` is 1.
- R7: Ratio codes 101, 110 and 111 are reserved: the block runs at quarter rate (as R1) and `cfg_err` is 1.
- R8: A new ratio code takes effect only after the last cycle of the period in progress, and the new rate starts at the first cycle of its own period.
- R9: While `rst_n` is low, `pix_en` and `cfg_err` are 0. After release the block runs at quarter rate, and the first pulse falls in the fourth cycle after release (counting the cycle right after release as the first).
- R10: `cfg_err` is registered. It shows the legality of the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 3 | Ratio code: 000 /4, 001 /3, 010 /2, 011 two-thirds, 100 full rate, others reserved |
| osc_src | input | 2 | Oscillator-source code; 00 forbids full rate |
| pix_en | output | 1 | Single-cycle pixel enable strobe |
| cfg_err | output | 1 | Registered flag for a reserved or prohibited setting |

## Verification
`pix_en` is a combinational decode of registered phase and mode state. It is therefore due in the same cycle as that state, and a new ratio code reaches it only in the cycle after the period boundary edge. `cfg_err` is due one edge after the inputs that cause it. The bench releases reset with each of the 32 code combinations already applied and samples at every falling edge. It expects four quarter-rate cycles first and the new pattern from the fifth sampled cycle on. `cfg_err` is expected from the first cycle after the first edge out of reset. A directed mid-period change confirms that the old period finishes before the new rate starts.

// File: rtl/pixdiv_pkg.sv
// Shared types for the pixel clock enable divider.
// Assumes a maximum period of 4 master cycles.
package pixdiv_pkg;

    localparam int MAX_PERIOD = 4;
    localparam int PH_W       = $clog2(MAX_PERIOD);

    typedef enum logic [2:0] {
        MD_DIV4  = 3'd0,
        MD_DIV3  = 3'd1,
        MD_DIV2  = 3'd2,
        MD_TWO3  = 3'd3,
        MD_PASS  = 3'd4
    } pix_mode_t;

    // Last phase index of a period for each mode.
    function automatic logic [PH_W-1:0] last_phase(pix_mode_t m);
        case (m)
            MD_DIV4: last_phase = PH_W'(3);
            MD_DIV3: last_phase = PH_W'(2);
            MD_DIV2: last_phase = PH_W'(1);
            MD_TWO3: last_phase = PH_W'(2);
            default: last_phase = PH_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/pixdiv_decode.sv
// Maps the ratio and oscillator-source codes to an operating mode.
// Reserved and prohibited settings map to quarter rate.
// The error flag is registered; the mode request is combinational.
module pixdiv_decode
    import pixdiv_pkg::*;
#(
    parameter int SEL_W        = 3,
    parameter int OSC_W        = 2,
    parameter int PASS_CODE    = 4,
    parameter int FAST_OSC     = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic [OSC_W-1:0] osc_src,
    output pix_mode_t        req_mode,
    output logic             cfg_err
);

    logic bad_cfg;

    // Translate the codes into a requested mode and a legality flag.
    always_comb begin
        bad_cfg  = 1'b0;
        req_mode = MD_DIV4;
        case (ratio_sel)
            SEL_W'(0): req_mode = MD_DIV4;
            SEL_W'(1): req_mode = MD_DIV3;
            SEL_W'(2): req_mode = MD_DIV2;
            SEL_W'(3): req_mode = MD_TWO3;
            SEL_W'(PASS_CODE): begin
                if (osc_src == OSC_W'(FAST_OSC)) begin
                    req_mode = MD_DIV4;
                    bad_cfg  = 1'b1;
                end else begin
                    req_mode = MD_PASS;
                end
            end
            default: begin
                req_mode = MD_DIV4;
                bad_cfg  = 1'b1;
            end
        endcase
    end

    // Register the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= bad_cfg;
    end

endmodule

// File: rtl/pixdiv_phase.sv
// Phase counter and enable pattern generator.
// It holds the active mode and loads a new request only at a period boundary,
// where the phase restarts from zero.
module pixdiv_phase
    import pixdiv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  pix_mode_t       req_mode,
    output pix_mode_t       act_mode,
    output logic [PH_W-1:0] phase,
    output logic            pix_en
);

    logic boundary;

    // Detect the last cycle of the current period.
    always_comb boundary = (phase == last_phase(act_mode));

    // Advance the phase; at a boundary adopt the requested mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= MD_DIV4;
            phase    <= '0;
        end else if (boundary) begin
            act_mode <= req_mode;
            phase    <= '0;
        end else begin
            phase    <= phase + PH_W'(1);
        end
    end

    // Produce the enable pattern for the active mode.
    always_comb begin
        case (act_mode)
            MD_TWO3: pix_en = (phase != PH_W'(2));
            MD_PASS: pix_en = 1'b1;
            default: pix_en = boundary;
        endcase
    end

endmodule

// File: rtl/pixclk_div.sv
// Top level of the pixel clock enable divider.
// Emits a single-cycle enable and never gates the clock.
// Assumes the codes come from the clk domain.
module pixclk_div
    import pixdiv_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int OSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic [OSC_W-1:0] osc_src,
    output logic             pix_en,
    output logic             cfg_err
);

    pix_mode_t       req_mode;
    pix_mode_t       act_mode;
    logic [PH_W-1:0] phase;

    pixdiv_decode #(
        .SEL_W(SEL_W),
        .OSC_W(OSC_W)
    ) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_sel(ratio_sel),
        .osc_src  (osc_src),
        .req_mode (req_mode),
        .cfg_err  (cfg_err)
    );

    pixdiv_phase i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_mode(req_mode),
        .act_mode(act_mode),
        .phase   (phase),
        .pix_en  (pix_en)
    );

endmodule

// File: rtl/pixdiv_chk.sv
// Property checker for pixclk_div, attached through bind.
// Watches the ports plus the active mode and phase.
module pixdiv_chk
    import pixdiv_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int OSC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] ratio_sel,
    input logic [OSC_W-1:0] osc_src,
    input logic             pix_en,
    input logic             cfg_err,
    input pix_mode_t        act_mode,
    input logic [PH_W-1:0]  phase
);

    logic illegal_in;
    always_comb illegal_in = (ratio_sel > SEL_W'(4)) ||
                             (ratio_sel == SEL_W'(4) && osc_src == '0);

    // R10
    err_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cfg_err == $past(illegal_in)));

    // R8
    mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && act_mode != $past(act_mode)) |-> (phase == '0));

    // R5
    pass_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == MD_PASS) |-> pix_en);

    // R4
    two3_no_double_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && act_mode == MD_TWO3 && $past(act_mode) == MD_TWO3 && !$past(pix_en))
        |-> pix_en);

    // R1
    div4_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && act_mode == MD_DIV4 && $past(act_mode) == MD_DIV4 && pix_en)
        |-> !$past(pix_en));

    // R8
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= last_phase(act_mode));

endmodule

bind pixclk_div pixdiv_chk #(
    .SEL_W(SEL_W),
    .OSC_W(OSC_W)
) u_pixdiv_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_sel(ratio_sel),
    .osc_src  (osc_src),
    .pix_en   (pix_en),
    .cfg_err  (cfg_err),
    .act_mode (act_mode),
    .phase    (phase)
);

// File: tb/test_pixclk_div.sv
// Sweeps every ratio/oscillator code pair out of reset and checks the strobe
// pattern and error flag arithmetically; a directed case covers a mid-period change.
module test_pixclk_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic [1:0] osc_src = 2'd0;
    logic       pix_en;
    logic       cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pixclk_div i_pixclk_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_sel(ratio_sel),
        .osc_src  (osc_src),
        .pix_en   (pix_en),
        .cfg_err  (cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected enable for cycle j of a period train with the given code pair.
    function automatic int exp_en(input int sel, input int osc, input int j);
        if (sel == 1) return (j % 3 == 2) ? 1 : 0;
        if (sel == 2) return (j % 2 == 1) ? 1 : 0;
        if (sel == 3) return (j % 3 != 2) ? 1 : 0;
        if (sel == 4 && osc != 0) return 1;
        return (j % 4 == 3) ? 1 : 0;
    endfunction

    function automatic string req_of(input int sel, input int osc);
        case (sel)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return (osc == 0) ? "R6" : "R5";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Full sweep of code pairs, each from reset.
        for (int sel = 0; sel < 8; sel++) begin
            for (int osc = 0; osc < 4; osc++) begin
                @(negedge clk);
                rst_n = 1'b0;
                ratio_sel = 3'(sel);
                osc_src = 2'(osc);
                repeat (2) @(negedge clk);
                chk("R9", int'(pix_en), 0, "pix_en in reset");
                chk("R9", int'(cfg_err), 0, "cfg_err in reset");
                rst_n = 1'b1;
                for (int k = 0; k < 24; k++) begin
                    int bad;
                    bad = (sel > 4 || (sel == 4 && osc == 0)) ? 1 : 0;
                    if (k < 4)
                        chk("R9", int'(pix_en), (k == 3) ? 1 : 0, "startup quarter rate");
                    else
                        chk(req_of(sel, osc), int'(pix_en), exp_en(sel, osc, k - 4), "pattern");
                    chk("R10", int'(cfg_err), (k == 0) ? 0 : bad, "error flag");
                    @(negedge clk);
                end
            end
        end

        // R8: switch from /3 to /2 in the middle of a /3 period.
        rst_n = 1'b0;
        ratio_sel = 3'd1;
        osc_src = 2'd1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 14; k++) begin
            int e;
            if (k < 4)      e = (k == 3) ? 1 : 0;
            else if (k < 7) e = exp_en(1, 1, k - 4);
            else            e = exp_en(2, 1, k - 7);
            chk("R8", int'(pix_en), e, "mid-period change");
            if (k == 5) ratio_sel = 3'd2;
            @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule